// File: doc/BRIEF.md
# Floating-Point Exception Result Handler

This block sits behind a single-precision arithmetic unit and decides what happens when an operation reports an exceptional condition. For every valid operation it takes the raised exception bits (overflow, underflow, inexact, divide-by-zero, invalid) and the sign of the result. It combines them with the rounding mode, the per-exception enable bits and a denormal-handling control bit, all held in its own 32-bit status register. From these it produces three outputs. The first is the value, if any, to write into the destination register. The second is the set of sticky flags to record. The third is whether a trap request or an unimplemented-operation request is raised.

A masked overflow produces either an infinity or the largest finite magnitude, chosen by the rounding direction and the sign. A masked underflow either returns a signed zero or escalates to an unimplemented-operation request. An enabled exception leaves the destination untouched and raises a trap instead. All decisions are registered: they appear one clock after the operation is presented. Software reads and writes the status register through a plain write port and a continuous read-back.

Top module: `fpx_result_handler`

## Requirements
- R1: While and right after `rst` is high, `dst_we`, `trap_req`, `unimpl_req`, `dst_data` and `csr_rd_data` are all zero.
- R2: The rounding mode is held in status bits 1:0, with 00 meaning nearest. A masked overflow (status bit 20 = 0) under mode 00 writes 0x7F800000 for a positive sign and 0xFF800000 for a negative sign.
- R3: A masked overflow under mode 01 (toward zero) writes the largest finite magnitude with the result sign: 0x7F7FFFFF or 0xFF7FFFFF.
- R4: A masked overflow under mode 10 (toward plus infinity) writes 0x7F800000 for positive and 0xFF7FFFFF for negative. Under mode 11 (toward minus infinity) it writes 0x7F7FFFFF for positive and 0xFF800000 for negative.
- R5: When the overflow enable (status bit 20) or the underflow enable (status bit 18) is 1 and that exception occurs, `dst_we` stays 0 and `trap_req` is 1 for exactly one cycle.
- R6: A masked overflow also counts as inexact. It sets sticky bit 6 along with overflow sticky bit 4. If the inexact enable (status bit 19) is 1, it raises `trap_req` and suppresses the write.
- R7: A masked underflow with the denormal control (status bit 23) at 1 writes a zero that carries the result sign (0x00000000 or 0x80000000) and sets underflow sticky bit 5.
- R8: A masked underflow with status bit 23 at 0 writes nothing. It pulses `unimpl_req` for one cycle and sets sticky bit 7.
- R9: Sticky bits are 2 (invalid), 3 (divide-by-zero), 4 (overflow), 5 (underflow), 6 (inexact) and 7 (unimplemented). They stay set until a register write clears them. Only bits 23:18, 7:2 and 1:0 are writable; all other bits read as zero.
- R10: When a register write and a new exception fall in the same cycle, each flag raised by the exception ends up set. Every other bit takes the written value.
- R11: Divide-by-zero and invalid set their sticky flags and never write the destination. They raise `trap_req` when their enables (bit 21 and bit 22 respectively) are 1.
- R12: Outputs appear in the cycle after `op_valid`. In a cycle following no valid operation, `dst_we`, `trap_req` and `unimpl_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation result with exception status is presented |
| exc_ovf | input | 1 | Overflow detected |
| exc_udf | input | 1 | Underflow detected |
| exc_ixct | input | 1 | Inexact detected |
| exc_div0 | input | 1 | Divide by zero detected |
| exc_ivld | input | 1 | Invalid operation detected |
| res_sign | input | 1 | Sign of the exceptional result |
| csr_wr_en | input | 1 | Status register write strobe |
| csr_wr_data | input | 32 | Status register write value |
| csr_rd_data | output | 32 | Status register contents |
| dst_data | output | 32 | Value to write to the destination register |
| dst_we | output | 1 | Destination write enable |
| trap_req | output | 1 | Trap request, one cycle per faulting operation |
| unimpl_req | output | 1 | Unimplemented-operation request |

## Verification
Two functions can land on the same clock edge: a software write to the status register and the sticky-flag update caused by a new exception. The bench first loads the register with some flags already set. Then, in the same cycle, it issues a write of all zeros together with a masked overflow. The read-back one cycle later must show only the overflow and inexact flags. This proves that the write cleared the old flags and that the new exception won for its own bits.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_MINF = 2'b11
  } rmode_t;

  // sticky flags, ivld at LSB (status bits 7:2)
  typedef struct packed {
    logic unimpl;
    logic ixct;
    logic udf;
    logic ovf;
    logic div0;
    logic ivld;
  } flags_t;

  // trap enables (status bits 22:18)
  typedef struct packed {
    logic ivld;
    logic div0;
    logic ovf;
    logic ixct;
    logic udf;
  } enables_t;

  localparam int RM_LSB   = 0;
  localparam int FLG_LSB  = 2;
  localparam int FLG_W    = $bits(flags_t);
  localparam int EN_LSB   = 18;
  localparam int EN_W     = $bits(enables_t);
  localparam int DN_BIT   = EN_LSB + EN_W;

  localparam logic [30:0] MAG_INF = 31'h7F80_0000;
  localparam logic [30:0] MAG_MAX = 31'h7F7F_FFFF;
endpackage

// File: rtl/fpx_ovf_pick.sv
module fpx_ovf_pick
  import fpx_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic   sign,
  input  rmode_t rm,
  output logic [W-1:0] value
);
  logic to_inf;

  always_comb begin
    unique case (rm)
      RM_NEAR: to_inf = 1'b1;
      RM_ZERO: to_inf = 1'b0;
      RM_PINF: to_inf = ~sign;
      RM_MINF: to_inf = sign;
      default: to_inf = 1'b1;
    endcase
    value = {sign, (to_inf ? MAG_INF : MAG_MAX)};
  end
endmodule

// File: rtl/fpx_decide.sv
module fpx_decide
  import fpx_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic     ovf,
  input  logic     udf,
  input  logic     ixct,
  input  logic     div0,
  input  logic     ivld,
  input  logic     sign,
  input  rmode_t   rm,
  input  enables_t en,
  input  logic     dn,
  output flags_t   set,
  output logic     trap,
  output logic     unimpl,
  output logic     we,
  output logic [W-1:0] data
);
  logic ovf_masked, udf_masked, ixct_eff, have_res;
  logic [W-1:0] ovf_val;

  fpx_ovf_pick #(.W(W)) u_pick (
    .sign  (sign),
    .rm    (rm),
    .value (ovf_val)
  );

  always_comb begin
    ovf_masked = ovf & ~en.ovf;
    udf_masked = udf & ~en.udf;
    ixct_eff   = ixct | ovf_masked;
    unimpl     = udf_masked & ~dn;
    trap       = (ovf & en.ovf) | (udf & en.udf) | (ixct_eff & en.ixct)
               | (div0 & en.div0) | (ivld & en.ivld);

    set.ivld   = ivld;
    set.div0   = div0;
    set.ovf    = ovf;
    set.udf    = udf;
    set.ixct   = ixct_eff;
    set.unimpl = unimpl;

    have_res = ovf_masked | (udf_masked & dn);
    we       = have_res & ~trap & ~unimpl;
    if (ovf_masked) data = ovf_val;
    else            data = {sign, {(W-1){1'b0}}};
  end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         upd,
  input  flags_t       set,
  output rmode_t       rm,
  output enables_t     en,
  output logic         dn,
  output logic [W-1:0] rd_data
);
  flags_t   flags_q;
  enables_t en_q;
  rmode_t   rm_q;
  logic     dn_q;
  flags_t   set_g;
  flags_t   flags_base;

  always_comb begin
    set_g      = upd ? set : '0;
    flags_base = wr_en ? flags_t'(wr_data[FLG_LSB +: FLG_W]) : flags_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
      rm_q    <= RM_NEAR;
      dn_q    <= 1'b0;
    end else begin
      flags_q <= flags_base | set_g;
      if (wr_en) begin
        en_q <= enables_t'(wr_data[EN_LSB +: EN_W]);
        rm_q <= rmode_t'(wr_data[RM_LSB +: 2]);
        dn_q <= wr_data[DN_BIT];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[RM_LSB +: 2]     = rm_q;
    rd_data[FLG_LSB +: FLG_W] = flags_q;
    rd_data[EN_LSB +: EN_W]   = en_q;
    rd_data[DN_BIT]           = dn_q;
  end

  assign rm = rm_q;
  assign en = en_q;
  assign dn = dn_q;

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    ((flags_q & $past(set_g)) == $past(set_g)));
endmodule

// File: rtl/fpx_result_handler.sv
module fpx_result_handler
  import fpx_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic         exc_ovf,
  input  logic         exc_udf,
  input  logic         exc_ixct,
  input  logic         exc_div0,
  input  logic         exc_ivld,
  input  logic         res_sign,
  input  logic         csr_wr_en,
  input  logic [W-1:0] csr_wr_data,
  output logic [W-1:0] csr_rd_data,
  output logic [W-1:0] dst_data,
  output logic         dst_we,
  output logic         trap_req,
  output logic         unimpl_req
);
  rmode_t   rm;
  enables_t en;
  logic     dn;
  flags_t   set;
  logic     d_trap, d_unimpl, d_we;
  logic [W-1:0] d_data;
  logic     valid_q;

  fpx_status_reg #(.W(W)) u_csr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (csr_wr_en),
    .wr_data (csr_wr_data),
    .upd     (op_valid),
    .set     (set),
    .rm      (rm),
    .en      (en),
    .dn      (dn),
    .rd_data (csr_rd_data)
  );

  fpx_decide #(.W(W)) u_dec (
    .ovf    (exc_ovf),
    .udf    (exc_udf),
    .ixct   (exc_ixct),
    .div0   (exc_div0),
    .ivld   (exc_ivld),
    .sign   (res_sign),
    .rm     (rm),
    .en     (en),
    .dn     (dn),
    .set    (set),
    .trap   (d_trap),
    .unimpl (d_unimpl),
    .we     (d_we),
    .data   (d_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= 1'b0;
      dst_we     <= 1'b0;
      trap_req   <= 1'b0;
      unimpl_req <= 1'b0;
      dst_data   <= '0;
    end else begin
      valid_q    <= op_valid;
      dst_we     <= op_valid & d_we;
      trap_req   <= op_valid & d_trap;
      unimpl_req <= op_valid & d_unimpl;
      if (op_valid & d_we) dst_data <= d_data;
    end
  end

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (!dst_we && !trap_req && !unimpl_req));

  assert_trap_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> !dst_we);

  assert_unimpl_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    unimpl_req |-> !dst_we);

  assert_result_shape_R2: assert property (@(posedge clk) disable iff (rst)
    dst_we |-> (dst_data[W-2:0] == MAG_INF || dst_data[W-2:0] == MAG_MAX
                || dst_data[W-2:0] == '0));
endmodule

// File: tb/test_fpx_result_handler.sv
module test_fpx_result_handler;
  logic clk = 1'b0;
  logic rst;
  logic op_valid, exc_ovf, exc_udf, exc_ixct, exc_div0, exc_ivld, res_sign;
  logic csr_wr_en;
  logic [31:0] csr_wr_data, csr_rd_data, dst_data;
  logic dst_we, trap_req, unimpl_req;
  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  fpx_result_handler i_fpx_result_handler (
    .clk(clk), .rst(rst), .op_valid(op_valid),
    .exc_ovf(exc_ovf), .exc_udf(exc_udf), .exc_ixct(exc_ixct),
    .exc_div0(exc_div0), .exc_ivld(exc_ivld), .res_sign(res_sign),
    .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
    .dst_data(dst_data), .dst_we(dst_we), .trap_req(trap_req), .unimpl_req(unimpl_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [31:0] v);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_data = v;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  // drive one op at a negedge, return at the next negedge (outputs valid)
  task automatic do_op(input logic o, u, x, d, i, s);
    @(negedge clk);
    op_valid = 1'b1; exc_ovf = o; exc_udf = u; exc_ixct = x;
    exc_div0 = d; exc_ivld = i; res_sign = s;
    @(negedge clk);
    op_valid = 1'b0; exc_ovf = 0; exc_udf = 0; exc_ixct = 0; exc_div0 = 0; exc_ivld = 0;
  endtask

  task automatic t_reset();
    chk("R1 we", {31'd0, dst_we}, 32'd0);
    chk("R1 trap", {31'd0, trap_req}, 32'd0);
    chk("R1 unimpl", {31'd0, unimpl_req}, 32'd0);
    chk("R1 data", dst_data, 32'd0);
    chk("R1 csr", csr_rd_data, 32'd0);
  endtask

  task automatic t_ovf_round();
    logic [31:0] exp_tab [4][2];
    exp_tab[0][0] = 32'h7F800000; exp_tab[0][1] = 32'hFF800000; // R2
    exp_tab[1][0] = 32'h7F7FFFFF; exp_tab[1][1] = 32'hFF7FFFFF; // R3
    exp_tab[2][0] = 32'h7F800000; exp_tab[2][1] = 32'hFF7FFFFF; // R4
    exp_tab[3][0] = 32'h7F7FFFFF; exp_tab[3][1] = 32'hFF800000; // R4
    for (int m = 0; m < 4; m++) begin
      csr_write(32'(m));
      for (int s = 0; s < 2; s++) begin
        do_op(1, 0, 0, 0, 0, s[0]);
        chk(m == 0 ? "R2 value" : (m == 1 ? "R3 value" : "R4 value"), dst_data, exp_tab[m][s]);
        chk("R2 we", {31'd0, dst_we}, 32'd1);
        chk("R12 no trap", {31'd0, trap_req}, 32'd0);
      end
    end
    @(negedge clk);
    chk("R12 idle we", {31'd0, dst_we}, 32'd0);
  endtask

  task automatic t_enabled_trap();
    csr_write(32'h0010_0000);
    do_op(1, 0, 0, 0, 0, 0);
    chk("R5 ovf we", {31'd0, dst_we}, 32'd0);
    chk("R5 ovf trap", {31'd0, trap_req}, 32'd1);
    @(negedge clk);
    chk("R5 trap one cycle", {31'd0, trap_req}, 32'd0);
    csr_write(32'h0004_0000);
    do_op(0, 1, 0, 0, 0, 1);
    chk("R5 udf we", {31'd0, dst_we}, 32'd0);
    chk("R5 udf trap", {31'd0, trap_req}, 32'd1);
  endtask

  task automatic t_inexact();
    csr_write(32'h0);
    do_op(1, 0, 0, 0, 0, 0);
    chk("R6 flags", csr_rd_data, 32'h0000_0050);
    chk("R6 no trap", {31'd0, trap_req}, 32'd0);
    csr_write(32'h0008_0000);
    do_op(1, 0, 0, 0, 0, 0);
    chk("R6 ixct trap", {31'd0, trap_req}, 32'd1);
    chk("R6 ixct no write", {31'd0, dst_we}, 32'd0);
  endtask

  task automatic t_underflow();
    csr_write(32'h0080_0000);
    do_op(0, 1, 0, 0, 0, 1);
    chk("R7 neg zero", dst_data, 32'h8000_0000);
    chk("R7 we", {31'd0, dst_we}, 32'd1);
    chk("R7 flag", csr_rd_data, 32'h0080_0020);
    do_op(0, 1, 0, 0, 0, 0);
    chk("R7 pos zero", dst_data, 32'h0000_0000);
    csr_write(32'h0);
    do_op(0, 1, 0, 0, 0, 0);
    chk("R8 no write", {31'd0, dst_we}, 32'd0);
    chk("R8 unimpl", {31'd0, unimpl_req}, 32'd1);
    chk("R8 flag", csr_rd_data, 32'h0000_00A0);
    @(negedge clk);
    chk("R8 unimpl one cycle", {31'd0, unimpl_req}, 32'd0);
  endtask

  task automatic t_div_ivld();
    csr_write(32'h0020_0000);
    do_op(0, 0, 0, 1, 0, 0);
    chk("R11 div0 trap", {31'd0, trap_req}, 32'd1);
    chk("R11 div0 no write", {31'd0, dst_we}, 32'd0);
    do_op(0, 0, 0, 0, 1, 0);
    chk("R11 ivld masked trap", {31'd0, trap_req}, 32'd0);
    chk("R11 ivld no write", {31'd0, dst_we}, 32'd0);
    chk("R11 flags", csr_rd_data, 32'h0020_000C);
  endtask

  task automatic t_sticky();
    repeat (3) @(negedge clk);
    chk("R9 hold", csr_rd_data, 32'h0020_000C);
    csr_write(32'hFFFF_FFFF);
    chk("R9 writable mask", csr_rd_data, 32'h00FC_00FF);
    csr_write(32'h0);
    chk("R9 clear", csr_rd_data, 32'h0);
  endtask

  task automatic t_collision();
    csr_write(32'h0000_000C);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_data = 32'h0;
    op_valid = 1'b1; exc_ovf = 1'b1; res_sign = 1'b0;
    @(negedge clk);
    csr_wr_en = 1'b0; op_valid = 1'b0; exc_ovf = 1'b0;
    chk("R10 exception wins", csr_rd_data, 32'h0000_0050);
    chk("R10 result", dst_data, 32'h7F80_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 0; exc_ovf = 0; exc_udf = 0; exc_ixct = 0;
    exc_div0 = 0; exc_ivld = 0; res_sign = 0; csr_wr_en = 0; csr_wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ovf_round();
    t_enabled_trap();
    t_inexact();
    t_underflow();
    t_div_ivld();
    t_sticky();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule